// File: doc/BRIEF.md
# USB Start-of-Frame Tracker

This block follows Start-of-Frame activity on the upstream port of a full-speed USB device. A packet decoder sends it a one-cycle strobe with the 11-bit frame number of each valid SOF. A separate frame timer sends it a strobe whenever an expected SOF has not arrived. Bus-level events also reach it: USB reset, the end of a resume and entry into suspend. From these inputs it keeps a lock flag, a count of SOFs missed in a row and the last frame number. It also emits a one-cycle interrupt pulse for every accepted SOF.

Firmware and neighbouring logic read a single 16-bit status word. The word holds the frame number, the missed-SOF count and the lock flag. It also holds the D+ and D- receive line levels, which pass through a synchronizer first. Wake-up handling uses these line levels to work out what ended a suspend. All state is registered: an input event seen at one clock edge shows in the status word and interrupt output after that same edge.

Top module: `sof_frame_tracker`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the status word and the interrupt output both become zero.
- R2: `sof_irq_o` is high for exactly the one cycle after each cycle in which `sof_valid_i` is high, and is low after every cycle in which it is low.
- R3: Bits 10:0 of the status word take the value of `sof_frame_i` in the same cycle that the interrupt pulse for that SOF appears.
- R4: Bits 10:0 keep their value through every cycle with no SOF strobe.
- R5: Bits 12:11 hold the missed-SOF count. It rises by one for each `esof_i` strobe in a cycle without an SOF strobe.
- R6: The missed-SOF count saturates at 3. Further ESOF strobes leave it at 3.
- R7: An SOF strobe returns the missed-SOF count to 0, including when an ESOF strobe arrives in the same cycle.
- R8: Bit 13 (lock) goes high after the second SOF strobe in an unbroken run. A run starts after the block reset, a bus reset, a resume-complete strobe or an ESOF strobe. Lock never goes high in a cycle without an SOF strobe.
- R9: While lock is low, an ESOF strobe between two SOFs restarts the run, so two further SOFs are needed.
- R10: Once high, lock stays high through ESOF strobes and resume-complete strobes. It clears only on `bus_reset_i` or `suspend_i`.
- R11: A `resume_done_i` strobe restarts the run, so an SOF received before it does not count toward lock.
- R12: When a bus reset and an SOF strobe arrive in the same cycle, lock and the run both clear, and the frame number is still captured.
- R13: Bit 15 shows `dp_i` and bit 14 shows `dm_i` through two register stages. A level present at one edge appears in the status word after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_valid_i | input | 1 | One-cycle strobe for a valid SOF packet |
| sof_frame_i | input | 11 | Frame number carried by the SOF |
| esof_i | input | 1 | One-cycle strobe from the frame timer: expected SOF missing |
| bus_reset_i | input | 1 | One-cycle strobe: USB reset seen on the bus |
| resume_done_i | input | 1 | One-cycle strobe: resume sequence finished |
| suspend_i | input | 1 | One-cycle strobe: suspend entered |
| dp_i | input | 1 | Raw D+ receive level, asynchronous |
| dm_i | input | 1 | Raw D- receive level, asynchronous |
| status_o | output | 16 | {D+, D-, lock, missed count[1:0], frame[10:0]} |
| sof_irq_o | output | 1 | One-cycle pulse per accepted SOF |

## Verification
The properties treat every event input as a sampled strobe. They make no assumption about spacing, so simultaneous SOF and ESOF strobes, and simultaneous reset and SOF strobes, fall under the stated priorities. The properties do assume that the raw line inputs are only ever seen through the synchronizer, which is why no property checks the line bits. The stimulus changes every input just after the falling edge and holds it for whole cycles. It creates the same-cycle collisions on purpose, to reach the priority cases of R7 and R12.

// File: rtl/sof_tracker_pkg.sv
package sof_tracker_pkg;
  localparam int FRAME_W_DEF = 11;
  localparam int LOST_W_DEF  = 2;
  localparam int RUN_LEN_DEF = 2;
  localparam int SYNC_DEF    = 2;
  localparam int LINES       = 2;

  // index of each receive line inside the synchronized vector
  localparam int LINE_DP = 1;
  localparam int LINE_DM = 0;
endpackage

// File: rtl/sof_line_sync.sv
module sof_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          pipe_q[s] <= '0;
        end else if (s == 0) begin
          pipe_q[s] <= raw_i;
        end else begin
          pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sof_frame_capture.sv
module sof_frame_capture #(
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sof_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= sof_i;
      if (sof_i) frame_o <= frame_i;
    end
  end
endmodule

// File: rtl/sof_lost_counter.sv
module sof_lost_counter #(
  parameter int LOST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_i,
  input  logic              esof_i,
  output logic [LOST_W-1:0] count_o
);
  localparam logic [LOST_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || sof_i) begin
      count_o <= '0;
    end else if (esof_i && count_o != CNT_MAX) begin
      count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/sof_lock_tracker.sv
module sof_lock_tracker #(
  parameter int RUN_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sof_i,
  input  logic esof_i,
  input  logic bus_reset_i,
  input  logic resume_i,
  input  logic suspend_i,
  output logic lock_o
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_LEN);

  logic [RUN_W-1:0] run_q, run_base, run_next;
  logic             drop, restart;

  assign drop    = bus_reset_i | suspend_i;
  assign restart = resume_i | esof_i;

  always_comb begin
    run_base = restart ? '0 : run_q;
    run_next = run_base;
    if (sof_i && run_base < RUN_TOP) run_next = run_base + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || drop) begin
      run_q  <= '0;
      lock_o <= 1'b0;
    end else begin
      run_q  <= run_next;
      lock_o <= lock_o | (run_next == RUN_TOP);
    end
  end
endmodule

// File: rtl/sof_frame_tracker.sv
module sof_frame_tracker
  import sof_tracker_pkg::*;
#(
  parameter int FRAME_W = FRAME_W_DEF,
  parameter int LOST_W  = LOST_W_DEF,
  parameter int RUN_LEN = RUN_LEN_DEF,
  parameter int SYNC_N  = SYNC_DEF,
  localparam int STAT_W = LINES + 1 + LOST_W + FRAME_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sof_valid_i,
  input  logic [FRAME_W-1:0] sof_frame_i,
  input  logic               esof_i,
  input  logic               bus_reset_i,
  input  logic               resume_done_i,
  input  logic               suspend_i,
  input  logic               dp_i,
  input  logic               dm_i,
  output logic [STAT_W-1:0]  status_o,
  output logic               sof_irq_o
);
  logic [LINES-1:0]   line_raw, line_sync;
  logic [FRAME_W-1:0] frame_q;
  logic [LOST_W-1:0]  lost_q;
  logic               lock_q;

  always_comb begin
    line_raw          = '0;
    line_raw[LINE_DP] = dp_i;
    line_raw[LINE_DM] = dm_i;
  end

  sof_line_sync #(.STAGES(SYNC_N), .WIDTH(LINES)) u_sync (
    .clk(clk), .rst(rst), .raw_i(line_raw), .sync_o(line_sync)
  );

  sof_frame_capture #(.FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst(rst), .sof_i(sof_valid_i), .frame_i(sof_frame_i),
    .frame_o(frame_q), .irq_o(sof_irq_o)
  );

  sof_lost_counter #(.LOST_W(LOST_W)) u_lost (
    .clk(clk), .rst(rst), .sof_i(sof_valid_i), .esof_i(esof_i),
    .count_o(lost_q)
  );

  sof_lock_tracker #(.RUN_LEN(RUN_LEN)) u_lock (
    .clk(clk), .rst(rst), .sof_i(sof_valid_i), .esof_i(esof_i),
    .bus_reset_i(bus_reset_i), .resume_i(resume_done_i),
    .suspend_i(suspend_i), .lock_o(lock_q)
  );

  assign status_o = {line_sync[LINE_DP], line_sync[LINE_DM], lock_q, lost_q, frame_q};
endmodule

// File: rtl/sof_frame_tracker_checker.sv
module sof_frame_tracker_checker #(
  parameter int FRAME_W = 11,
  parameter int LOST_W  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               sof_valid_i,
  input logic [FRAME_W-1:0] sof_frame_i,
  input logic               esof_i,
  input logic               bus_reset_i,
  input logic               suspend_i,
  input logic               lock_o,
  input logic [LOST_W-1:0]  lost_o,
  input logic [FRAME_W-1:0] frame_o,
  input logic               sof_irq_o
);
  localparam logic [LOST_W-1:0] LMAX = '1;

  a_r2_irq_follows_sof: assert property (@(posedge clk) disable iff (rst)
    sof_valid_i |=> sof_irq_o);
  a_r2_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    !sof_valid_i |=> !sof_irq_o);
  a_r3_frame_capture: assert property (@(posedge clk) disable iff (rst)
    sof_valid_i |=> frame_o == $past(sof_frame_i));
  a_r4_frame_hold: assert property (@(posedge clk) disable iff (rst)
    !sof_valid_i |=> $stable(frame_o));
  a_r5_lost_step: assert property (@(posedge clk) disable iff (rst)
    (esof_i && !sof_valid_i && lost_o != LMAX) |=> lost_o == $past(lost_o) + 1'b1);
  a_r6_lost_saturate: assert property (@(posedge clk) disable iff (rst)
    (esof_i && !sof_valid_i && lost_o == LMAX) |=> lost_o == LMAX);
  a_r7_lost_clear: assert property (@(posedge clk) disable iff (rst)
    sof_valid_i |=> lost_o == '0);
  a_r8_lock_needs_sof: assert property (@(posedge clk) disable iff (rst)
    (!lock_o && !sof_valid_i) |=> !lock_o);
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    (lock_o && !bus_reset_i && !suspend_i) |=> lock_o);
  a_r10_lock_drop: assert property (@(posedge clk) disable iff (rst)
    (bus_reset_i || suspend_i) |=> !lock_o);
endmodule

bind sof_frame_tracker sof_frame_tracker_checker #(
  .FRAME_W(FRAME_W), .LOST_W(LOST_W)
) u_chk (
  .clk(clk), .rst(rst), .sof_valid_i(sof_valid_i), .sof_frame_i(sof_frame_i),
  .esof_i(esof_i), .bus_reset_i(bus_reset_i), .suspend_i(suspend_i),
  .lock_o(status_o[FRAME_W+LOST_W]), .lost_o(status_o[FRAME_W+LOST_W-1:FRAME_W]),
  .frame_o(status_o[FRAME_W-1:0]), .sof_irq_o(sof_irq_o)
);

// File: tb/sof_frame_tracker_test.sv
module sof_frame_tracker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sof_valid_i = 1'b0;
  logic [10:0] sof_frame_i = '0;
  logic        esof_i = 1'b0, bus_reset_i = 1'b0, resume_done_i = 1'b0;
  logic        suspend_i = 1'b0, dp_i = 1'b0, dm_i = 1'b0;
  logic [15:0] status_o;
  logic        sof_irq_o;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  sof_frame_tracker uut (
    .clk(clk), .rst(rst), .sof_valid_i(sof_valid_i), .sof_frame_i(sof_frame_i),
    .esof_i(esof_i), .bus_reset_i(bus_reset_i), .resume_done_i(resume_done_i),
    .suspend_i(suspend_i), .dp_i(dp_i), .dm_i(dm_i),
    .status_o(status_o), .sof_irq_o(sof_irq_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_strobes();
    sof_valid_i = 0; esof_i = 0; bus_reset_i = 0; resume_done_i = 0; suspend_i = 0;
  endtask

  task automatic sof(input logic [10:0] fn);
    sof_valid_i = 1; sof_frame_i = fn; tick(); clear_strobes();
  endtask
  task automatic esof();   esof_i = 1;        tick(); clear_strobes(); endtask
  task automatic breset(); bus_reset_i = 1;   tick(); clear_strobes(); endtask
  task automatic resume(); resume_done_i = 1; tick(); clear_strobes(); endtask
  task automatic susp();   suspend_i = 1;     tick(); clear_strobes(); endtask

  task automatic t_reset();
    rst = 1; sof_valid_i = 1; sof_frame_i = 11'h7ff; dp_i = 1; dm_i = 1;
    tick(); tick(); tick();
    check("R1 status", status_o, 16'h0000);
    check("R1 irq", {15'd0, sof_irq_o}, 16'h0);
    clear_strobes(); dp_i = 0; dm_i = 0; tick(); tick(); rst = 0; tick();
  endtask

  task automatic t_frame_irq();
    sof(11'h155);
    check("R2 irq pulse", {15'd0, sof_irq_o}, 16'h1);
    check("R3 frame", {5'd0, status_o[10:0]}, 16'h0155);
    tick();
    check("R2 irq ends", {15'd0, sof_irq_o}, 16'h0);
    sof_frame_i = 11'h2aa; tick(); tick();
    check("R4 frame holds", {5'd0, status_o[10:0]}, 16'h0155);
    sof(11'h2aa); sof(11'h2ab);
    check("R2 back-to-back irq", {15'd0, sof_irq_o}, 16'h1);
    check("R3 second frame", {5'd0, status_o[10:0]}, 16'h02ab);
  endtask

  task automatic t_lost();
    sof(11'h010);
    check("R7 lost zero", {14'd0, status_o[12:11]}, 16'h0);
    esof();
    check("R5 lost 1", {14'd0, status_o[12:11]}, 16'h1);
    esof();
    check("R5 lost 2", {14'd0, status_o[12:11]}, 16'h2);
    esof(); esof(); esof();
    check("R6 lost saturates", {14'd0, status_o[12:11]}, 16'h3);
    sof(11'h011);
    check("R7 sof clears lost", {14'd0, status_o[12:11]}, 16'h0);
    esof(); esof();
    sof_valid_i = 1; esof_i = 1; sof_frame_i = 11'h012; tick(); clear_strobes();
    check("R7 sof beats esof", {14'd0, status_o[12:11]}, 16'h0);
  endtask

  task automatic t_lock();
    breset();
    sof(11'h020);
    check("R8 one sof no lock", {15'd0, status_o[13]}, 16'h0);
    sof(11'h021);
    check("R8 two sofs lock", {15'd0, status_o[13]}, 16'h1);
  endtask

  task automatic t_esof_break();
    breset();
    sof(11'h030); esof(); sof(11'h031);
    check("R9 esof breaks run", {15'd0, status_o[13]}, 16'h0);
    sof(11'h032);
    check("R9 relock after break", {15'd0, status_o[13]}, 16'h1);
  endtask

  task automatic t_lock_drop();
    esof(); esof(); esof(); esof(); resume();
    check("R10 lock survives esof", {15'd0, status_o[13]}, 16'h1);
    breset();
    check("R10 bus reset drops", {15'd0, status_o[13]}, 16'h0);
    sof(11'h040); sof(11'h041); susp();
    check("R10 suspend drops", {15'd0, status_o[13]}, 16'h0);
  endtask

  task automatic t_resume();
    breset();
    sof(11'h050); resume(); sof(11'h051);
    check("R11 resume restarts run", {15'd0, status_o[13]}, 16'h0);
    sof(11'h052);
    check("R11 lock after resume", {15'd0, status_o[13]}, 16'h1);
  endtask

  task automatic t_reset_sof();
    bus_reset_i = 1; sof_valid_i = 1; sof_frame_i = 11'h123; tick(); clear_strobes();
    check("R12 lock cleared", {15'd0, status_o[13]}, 16'h0);
    check("R12 frame captured", {5'd0, status_o[10:0]}, 16'h0123);
    sof(11'h124);
    check("R12 run cleared", {15'd0, status_o[13]}, 16'h0);
    sof(11'h125);
    check("R12 relock", {15'd0, status_o[13]}, 16'h1);
  endtask

  task automatic t_lines();
    dp_i = 1; dm_i = 0; tick();
    check("R13 dp after one edge", {14'd0, status_o[15:14]}, 16'h0);
    tick();
    check("R13 dp after two edges", {14'd0, status_o[15:14]}, 16'h2);
    dp_i = 0; dm_i = 1; tick(); tick();
    check("R13 dm", {14'd0, status_o[15:14]}, 16'h1);
  endtask

  initial begin
    tick();
    t_reset();
    t_frame_irq();
    t_lost();
    t_lock();
    t_esof_break();
    t_lock_drop();
    t_resume();
    t_reset_sof();
    t_lines();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule